// File: doc/BRIEF.md
# Event-driven convolutional spiking layer

This block is one convolutional layer of a spiking network. It runs entirely on input events. Each input spike arrives as a channel address over a four-phase request/acknowledge handshake. The layer then updates, one neuron at a time, every integrate-and-fire neuron that the channel reaches. There are 4 filters, each 5 taps wide with stride 1, so one event can touch up to 20 neurons. The layer keeps only the valid convolution positions, which gives 1020 neurons per filter.

For each neuron reached, the layer does five things in order:
1. It fetches the signed 8-bit synaptic weight from a built-in table.
2. It reads the neuron's membrane voltage from a single-port RAM.
3. It adds the weight to the voltage. There is no leak and no multiply.
4. It compares the result with the threshold. On a crossing it subtracts the threshold and emits an output address event. Otherwise it clamps the result to the lower bound if needed.
5. It writes the result back to the RAM.

After reset, a clear pass sets every membrane voltage to zero before the first event is taken. The input acknowledge is held back until the whole sweep has finished and every output handshake it raised has completed. As a result, events never overlap.

Top module: `conv_spike_layer`

## Requirements
- R1: After reset the block clears all 4080 membrane voltages to zero, one per cycle. During that pass in_ack and out_req stay low, and an input request raised early is not acknowledged until the pass is over.
- R2: An input event is acknowledged only after its full 20-step sweep and all of its output handshakes are complete. in_ack then stays high until in_req falls, and in_ack and out_req are never high together.
- R3: Steps run filter-major. Filter 0 is swept over taps 0 to 4, then filter 1, filter 2 and filter 3. Output events leave in that order.
- R4: With k = 5·filter + tap, the weight is 20 + 3k for even k and −(70 + k) for odd k, as a signed 8-bit value.
- R5: An event on channel c reaches, for each filter f and tap t, the neuron at position p = c − t, and only when 0 ≤ p ≤ 1019. That neuron's output address is f·1020 + p. Taps whose position falls outside that range change no neuron.
- R6: A neuron's voltage increases by the weight. When the sum is at least VTHR (default 100), the neuron emits its address and keeps the sum minus VTHR.
- R7: When the sum is below VMIN (default −128), the stored voltage becomes VMIN. A stored voltage always lies in [VMIN, VTHR).
- R8: out_req stays high, with out_addr unchanged, until out_ack is seen. It then falls, and the sweep resumes only after out_ack is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Input event request |
| in_addr | input | 10 | Input channel address |
| in_ack | output | 1 | Input event acknowledge |
| out_req | output | 1 | Output spike request |
| out_addr | output | 12 | Output neuron address |
| out_ack | input | 1 | Output spike acknowledge |

## Verification
The in-module assertions check on every cycle the parts that are pure protocol:
- out_req is held until acknowledged, with a stable address.
- in_ack and out_req are mutually exclusive.
- in_ack is released once the request drops.
- Both handshakes stay quiet during the clear pass.
- Every written membrane value lies within [VMIN, VTHR).

Only the bench scenarios can show the arithmetic that matters. This covers the weight table, the edge-channel tap skipping, the filter-then-tap emission order, reset by subtraction, and the effect of the clamp on later firing. The bench shows these by comparing the exact sequence of output addresses with an independent model of the neuron array.

// File: rtl/conv_spike_layer.sv
module conv_spike_layer #(
  parameter int NCH  = 1024,
  parameter int NF   = 4,
  parameter int KSZ  = 5,
  parameter int WW   = 8,
  parameter int VW   = 16,
  parameter int VTHR = 100,
  parameter int VMIN = -128,
  localparam int NPOS = NCH - KSZ + 1,
  localparam int NTOT = NF * NPOS,
  localparam int AW   = $clog2(NCH),
  localparam int NAW  = $clog2(NTOT),
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1,
  localparam int TW   = (KSZ > 1) ? $clog2(KSZ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_req,
  input  logic [AW-1:0]  in_addr,
  output logic           in_ack,
  output logic           out_req,
  output logic [NAW-1:0] out_addr,
  input  logic           out_ack
);
  typedef enum logic [2:0] {S_CLR, S_IDLE, S_RD, S_UPD, S_OREQ, S_OREL, S_DONE} st_t;
  localparam logic signed [VW-1:0] THR = VW'(VTHR);
  localparam logic signed [VW-1:0] VLO = VW'(VMIN);

  st_t st;
  logic [NAW-1:0] clr;
  logic [AW-1:0]  chan;
  logic [FW-1:0]  f;
  logic [TW-1:0]  t;
  logic [VW-1:0]  mem [NTOT];
  logic signed [VW-1:0] rd, sum, nv;
  logic signed [WW-1:0] w;

  function automatic logic signed [WW-1:0] wgt(input int k);
    return (k % 2 == 1) ? WW'(-(70 + k)) : WW'(20 + 3 * k);
  endfunction

  logic [AW:0]    posx;
  logic           valid, last, fire, we;
  logic [NAW-1:0] naddr, ram_a;
  logic [VW-1:0]  wd;

  assign posx  = {1'b0, chan} - (AW+1)'(t);
  assign valid = !posx[AW] && (posx < (AW+1)'(NPOS));
  assign naddr = NAW'(f) * NAW'(NPOS) + NAW'(posx);
  assign last  = (int'(t) == KSZ - 1) && (int'(f) == NF - 1);
  assign w     = wgt(int'(f) * KSZ + int'(t));
  assign sum   = rd + VW'(w);
  assign fire  = sum >= THR;
  assign nv    = fire ? sum - THR : (sum < VLO ? VLO : sum);
  assign we    = (st == S_CLR) || (st == S_UPD);
  assign ram_a = (st == S_CLR) ? clr : naddr;
  assign wd    = (st == S_CLR) ? '0 : nv;

  always_ff @(posedge clk) begin
    if (we) mem[ram_a] <= wd;
    rd <= mem[ram_a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CLR; clr <= '0; chan <= '0; f <= '0; t <= '0;
      in_ack <= 1'b0; out_req <= 1'b0; out_addr <= '0;
    end else begin
      case (st)
        S_CLR: if (int'(clr) == NTOT - 1) st <= S_IDLE; else clr <= clr + 1'b1;
        S_IDLE: if (in_req) begin chan <= in_addr; f <= '0; t <= '0; st <= S_RD; end
        S_UPD: if (fire) begin out_addr <= naddr; out_req <= 1'b1; st <= S_OREQ; end
        S_OREQ: if (out_ack) begin out_req <= 1'b0; st <= S_OREL; end
        S_DONE: if (!in_ack) in_ack <= 1'b1;
                else if (!in_req) begin in_ack <= 1'b0; st <= S_IDLE; end
        default: ;
      endcase
      if ((st == S_RD && !valid) || (st == S_UPD && !fire) || (st == S_OREL && !out_ack)) begin
        if (int'(t) == KSZ - 1) begin t <= '0; f <= f + 1'b1; end else t <= t + 1'b1;
        st <= last ? S_DONE : S_RD;
      end else if (st == S_RD) st <= S_UPD;
    end
  end

  assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLR) |-> (!in_ack && !out_req));
  assert_ack_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ack && out_req));
  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_req) |=> !in_ack);
  assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) |-> (nv >= VLO && nv < THR));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req);
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_addr));
endmodule

// File: tb/conv_spike_layer_test.sv
module conv_spike_layer_test;
  localparam int NTOT = 4080;
  logic clk = 0, rst_n = 0, in_req = 0, out_ack = 0;
  logic [9:0] in_addr = '0;
  logic in_ack, out_req;
  logic [11:0] out_addr;
  int checks = 0, failures = 0, cyc = 0;
  int model [NTOT];
  int exp_q[$], got_q[$];

  conv_spike_layer uut (.clk(clk), .rst_n(rst_n), .in_req(in_req), .in_addr(in_addr),
    .in_ack(in_ack), .out_req(out_req), .out_addr(out_addr), .out_ack(out_ack));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wt(int k);
    return (k % 2 == 1) ? -(70 + k) : 20 + 3 * k;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0d expected=%0d", req, act, expv); end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    if (out_req && !out_ack) begin
      got_q.push_back(int'(out_addr));
      chk(!in_ack, "R2 in_ack during output", int'(in_ack), 0);
      repeat (2) @(negedge clk);
      chk(out_req, "R8 out_req held", int'(out_req), 1);
      out_ack = 1;
      while (out_req) @(negedge clk);
      @(negedge clk);
      out_ack = 0;
    end
  end

  task automatic predict(int c);
    for (int f = 0; f < 4; f++)
      for (int t = 0; t < 5; t++) begin
        int p = c - t;
        if (p >= 0 && p <= 1019) begin
          int a = f * 1020 + p;
          model[a] += wt(f * 5 + t);
          if (model[a] >= 100) begin exp_q.push_back(a); model[a] -= 100; end
          else if (model[a] < -128) model[a] = -128;
        end
      end
  endtask

  task automatic send(int c, string req);
    predict(c);
    @(negedge clk);
    in_addr = 10'(c); in_req = 1;
    while (!in_ack) @(negedge clk);
    in_req = 0;
    while (in_ack) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  task automatic t_reset();
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(!in_ack && !out_req, "R1 quiet during clear", int'(in_ack) + int'(out_req), 0);
    t0 = cyc;
    predict(0);
    in_addr = 10'd0; in_req = 1;
    while (!in_ack) @(negedge clk);
    chk(cyc - t0 >= NTOT - 12, "R1 ack after clear", cyc - t0, NTOT - 12);
    in_req = 0;
    while (in_ack) @(negedge clk);
    chk(got_q.size() == 0, "R1 zero start, no spikes", got_q.size(), 0);
    exp_q.delete(); got_q.delete();
  endtask

  task automatic t_edges();
    send(1023, "R5 top edge");
    send(1023, "R5 top edge fire");
    send(1, "R5 low edge");
    send(1, "R5 low edge repeat");
    send(1022, "R5 near top");
  endtask

  task automatic t_center();
    for (int i = 0; i < 6; i++) send(500, "R3 R4 R6 full sweep order");
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 3; i++) send(601, "R7 drive below floor");
    for (int i = 0; i < 12; i++) send(600, "R7 recovery from floor");
  endtask

  task automatic t_mix();
    int s = 7;
    for (int i = 0; i < 40; i++) begin
      s = (s * 29 + 11) % 1024;
      send(700 + (s % 9), "R3 R6 R7 mixed events");
    end
  endtask

  initial begin
    for (int i = 0; i < NTOT; i++) model[i] = 0;
    t_reset();
    t_edges();
    t_center();
    t_clamp();
    t_mix();
    finish_run();
  end
endmodule